// File: doc/BRIEF.md
# ROM Patch Trap Unit

This block watches the fetch program counter of a microcontroller that normally runs from ROM. It holds a small bank of trap registers. Each trap register stores one ROM address that needs a fix, and each trap has its own fixed entry point in RAM. When the fetch address equals an armed trap, the block raises a redirect and supplies that trap's RAM entry address, so the fetch logic can jump into downloaded replacement code instead of the faulty ROM code.

Software loads the patch code into RAM and enables RAM execution first. Only then does it arm the traps. The block enforces this order. A trap cannot be armed while RAM execution is off. Disarming is always possible. While RAM execution is off, all matching is suppressed. The redirect and target are combinational from the program counter and the stored trap values. Writes to the trap registers are registered and take effect on the following cycle.

Top module: `rom_patch_trap`

## Requirements
- R1: After a synchronous active-high reset, every trap register holds zero, and no redirect occurs for any program counter.
- R2: A write with `ram_exec_on` high stores `wr_value` into the trap register selected by `wr_sel`.
- R3: A write of a non-zero value while `ram_exec_on` is low is ignored, and the selected register keeps its previous value.
- R4: A write of zero is accepted whatever the state of `ram_exec_on`, and disarms the selected trap.
- R5: When RAM execution is on and `fetch_pc` equals a non-zero trap value, `redirect` is high in the same cycle. In that case `target_addr` equals ENTRY_BASE plus 4 times the trap index.
- R6: A trap register holding zero never matches, including when `fetch_pc` is zero.
- R7: While `ram_exec_on` is low, `redirect` stays low, even if some registers hold non-zero values that equal `fetch_pc`.
- R8: When several armed traps equal `fetch_pc`, the trap with the lowest index decides `target_addr`.
- R9: A write affects matching only from the cycle after the write edge. In the cycle that presents the write, matching still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Trap register write strobe |
| wr_sel | input | IDX_W | Index of the trap register to write |
| wr_value | input | ADDR_W | ROM address to trap; zero disarms |
| ram_exec_on | input | 1 | RAM microcode execution enabled and locked |
| fetch_pc | input | ADDR_W | Current fetch program counter |
| redirect | output | 1 | Fetch must jump to `target_addr` |
| target_addr | output | ADDR_W | RAM entry address of the winning trap |

## Verification
The bench builds the block with eight traps, the upper end of its intended range. This makes the full three-bit select field and the largest entry offset (index 7, offset 28) reachable. It also lets overlapping matches span distant indices. The bench overrides the entry base to a value other than the default, so that a target computed from the wrong base shows up. A random phase writes only a handful of addresses and toggles the enable, which produces frequent collisions between traps as well as refused arm attempts.

// File: rtl/rom_trap_pkg.sv
package rom_trap_pkg;
  // Spacing between consecutive RAM entry points, in address units.
  localparam int unsigned ENTRY_STRIDE = 4;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/trap_reg_bank.sv
module trap_reg_bank #(
  parameter int unsigned NUM_TRAPS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_sel,
  input  logic [ADDR_W-1:0]                 wr_value,
  input  logic                              exec_on,
  output logic [NUM_TRAPS-1:0][ADDR_W-1:0]  trap_q
);
  // Arming is refused until RAM execution is on; disarming is always allowed.
  logic write_allowed;
  assign write_allowed = wr_en && (exec_on || (wr_value == '0));

  for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_trap
    always_ff @(posedge clk) begin
      if (rst)
        trap_q[i] <= '0;
      else if (write_allowed && (wr_sel == IDX_W'(i)))
        trap_q[i] <= wr_value;
    end

    // R3: a refused arm leaves the register unchanged
    a_r3_refused_arm: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !exec_on && (wr_value != '0) && (wr_sel == IDX_W'(i)))
        |=> $stable(trap_q[i]));

    // R4: a zero write always disarms
    a_r4_disarm: assert property (@(posedge clk) disable iff (rst)
      (wr_en && (wr_value == '0) && (wr_sel == IDX_W'(i)))
        |=> (trap_q[i] == '0));

    // R2: an enabled write lands in the selected register
    a_r2_store: assert property (@(posedge clk) disable iff (rst)
      (wr_en && exec_on && (wr_sel == IDX_W'(i)))
        |=> (trap_q[i] == $past(wr_value)));
  end
endmodule

// File: rtl/trap_matcher.sv
module trap_matcher #(
  parameter int unsigned NUM_TRAPS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_TRAPS-1:0][ADDR_W-1:0]  trap_q,
  input  logic [ADDR_W-1:0]                 pc,
  input  logic                              exec_on,
  output logic                              hit_any,
  output logic [IDX_W-1:0]                  win_idx
);
  logic [NUM_TRAPS-1:0] hit;
  logic [NUM_TRAPS-1:0] grant;

  for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_cmp
    assign hit[i] = exec_on && (trap_q[i] != '0) && (trap_q[i] == pc);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest hit.
  always_comb begin
    win_idx = '0;
    grant   = '0;
    for (int i = NUM_TRAPS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_idx = IDX_W'(i);
        grant   = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign hit_any = |hit;

  // R8: at most one trap granted, and it is one that actually hit
  a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~hit) == '0));

  // R8: the granted trap has no lower-indexed hitting neighbour
  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> ((hit & ((grant) - 1'b1)) == '0));
endmodule

// File: rtl/rom_patch_trap.sv
module rom_patch_trap #(
  parameter int unsigned NUM_TRAPS  = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter logic [15:0] ENTRY_BASE = 16'h0800,
  localparam int unsigned IDX_W     = rom_trap_pkg::idx_width(NUM_TRAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_value,
  input  logic              ram_exec_on,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              redirect,
  output logic [ADDR_W-1:0] target_addr
);
  localparam logic [ADDR_W-1:0] BASE   = ADDR_W'(ENTRY_BASE);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(rom_trap_pkg::ENTRY_STRIDE);

  logic [NUM_TRAPS-1:0][ADDR_W-1:0] trap_q;
  logic                             hit_any;
  logic [IDX_W-1:0]                 win_idx;

  trap_reg_bank #(
    .NUM_TRAPS(NUM_TRAPS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_value(wr_value), .exec_on(ram_exec_on), .trap_q(trap_q)
  );

  trap_matcher #(
    .NUM_TRAPS(NUM_TRAPS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_match (
    .clk(clk), .rst(rst), .trap_q(trap_q), .pc(fetch_pc),
    .exec_on(ram_exec_on), .hit_any(hit_any), .win_idx(win_idx)
  );

  assign redirect    = hit_any;
  assign target_addr = BASE + ADDR_W'(win_idx) * STRIDE;

  // R7: no redirect while RAM execution is off
  a_r7_suppressed: assert property (@(posedge clk) disable iff (rst)
    !ram_exec_on |-> !redirect);

  // R6: a zero program counter can never be trapped
  a_r6_zero_never: assert property (@(posedge clk) disable iff (rst)
    (fetch_pc == '0) |-> !redirect);

  // R5: a redirect target lies on an entry slot of the vector table
  a_r5_target_slot: assert property (@(posedge clk) disable iff (rst)
    redirect |-> ((target_addr >= BASE) &&
                  (((target_addr - BASE) % STRIDE) == '0)));
endmodule

// File: tb/test_rom_patch_trap.sv
module test_rom_patch_trap;
  localparam int N    = 8;
  localparam int AW   = 16;
  localparam int IW   = 3;
  localparam logic [15:0] BASE = 16'h1200;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [IW-1:0] wr_sel;
  logic [AW-1:0] wr_value;
  logic          ram_exec_on;
  logic [AW-1:0] fetch_pc;
  logic          redirect;
  logic [AW-1:0] target_addr;

  int checks = 0;
  int fails  = 0;
  int model [N];

  always #2 clk = ~clk;

  rom_patch_trap #(.NUM_TRAPS(N), .ADDR_W(AW), .ENTRY_BASE(BASE)) i_rom_patch_trap (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_value(wr_value),
    .ram_exec_on(ram_exec_on), .fetch_pc(fetch_pc),
    .redirect(redirect), .target_addr(target_addr)
  );

  // One cycle: drive after the falling edge, compare, then advance the model.
  task automatic step(input string tag, input bit we, input int sel, input int val,
                      input bit en, input int pc);
    bit exp_red;
    int exp_tgt;
    @(negedge clk);
    wr_en = we; wr_sel = IW'(sel); wr_value = AW'(val);
    ram_exec_on = en; fetch_pc = AW'(pc);
    #1;
    exp_red = 1'b0; exp_tgt = -1;
    if (en && !rst)
      for (int i = 0; i < N; i++)
        if (!exp_red && model[i] != 0 && model[i] == pc) begin
          exp_red = 1'b1; exp_tgt = int'(BASE) + 4 * i;
        end
    checks++;
    if (redirect !== exp_red || (exp_red && target_addr !== AW'(exp_tgt))) begin
      fails++;
      $display("FAIL %s: redirect=%0b target=%h expected redirect=%0b target=%h",
               tag, redirect, target_addr, exp_red, AW'(exp_tgt));
    end
    @(posedge clk);
    if (rst) for (int i = 0; i < N; i++) model[i] = 0;
    else if (we && (en || val == 0)) model[sel] = val;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_sel = 0; wr_value = 0; ram_exec_on = 0; fetch_pc = 0;
    for (int i = 0; i < N; i++) model[i] = 0;
    @(posedge clk); @(posedge clk);
    rst = 1'b0;
    step("R1", 0, 0, 0, 1, 16'h0040);
    step("R6", 0, 0, 0, 1, 0);
    step("R3", 1, 0, 16'h0040, 0, 16'h0040);
    step("R3", 0, 0, 0, 1, 16'h0040);
    step("R9", 1, 0, 16'h0040, 1, 16'h0040);
    step("R2", 0, 0, 0, 1, 16'h0040);
    step("R5", 0, 0, 0, 1, 16'h0041);
    step("R2", 1, 3, 16'h0200, 1, 0);
    step("R2", 1, 5, 16'h0200, 1, 0);
    step("R2", 1, 7, 16'h0300, 1, 0);
    step("R8", 0, 0, 0, 1, 16'h0200);
    step("R5", 0, 0, 0, 1, 16'h0300);
    step("R7", 0, 0, 0, 0, 16'h0200);
    step("R7", 0, 0, 0, 0, 16'h0040);
    step("R4", 1, 3, 0, 0, 16'h0200);
    step("R4", 0, 0, 0, 1, 16'h0200);
    step("R6", 0, 0, 0, 1, 0);
    for (int k = 0; k < 400; k++) begin
      int pcs [4] = '{16'h0040, 16'h0200, 16'h0300, 16'h0555};
      bit we = ($urandom % 3) == 0;
      int val = ($urandom % 4 == 0) ? 0 : pcs[$urandom % 4];
      step("R8", we, $urandom % N, val, ($urandom % 5) != 0, pcs[$urandom % 4]);
    end
    rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < N; i++) model[i] = 0;
    rst = 1'b0;
    step("R1", 0, 0, 0, 1, 16'h0200);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule